// File: doc/BRIEF.md
# Quadrature Step Decoder

This block turns the two phase signals of a mechanical rotary encoder into single-cycle step pulses. The phases are brought into the clock domain through a flip-flop synchroniser. They are then examined only on cycles where an external sample strobe is high. A strobe rate of about 1 ms suits contact-bounce times on hand-turned knobs.

On each strobe the synchronised phase pair is compared with the pair kept from the previous strobe. The pair is stored, and any difference produces either an up pulse or a down pulse on the following cycle. A downstream decimal counter consumes the pulses.

Direction comes from a parity rule. It is the high bit of the change mask XORed with both bits of the new sample. A zero means up and a one means down. When both bits change within one sample, the same rule still yields a step, and an optional flag marks the event.

Top module: `quad_step_decoder`

## Requirements
- R1: While rst_ni is low, step_up_o, step_dn_o and dbl_flip_o are 0, and the stored phase pair is 2'b00. The first strobe after reset therefore compares against 2'b00.
- R2: A change of phase_i produces no pulse while sample_en_i is low. The stored pair is updated only on a strobe cycle.
- R3: A strobe whose synchronised sample equals the stored pair produces no pulse.
- R4: With phase_i[1:0] taken as a two-bit value, the visiting order 00, 10, 11, 01, 00 gives one step_up_o pulse per change.
- R5: The visiting order 00, 01, 11, 10, 00 gives one step_dn_o pulse per change.
- R6: When both phase bits differ from the stored pair, a step is still produced by the parity rule. Transitions 00→11 and 11→00 give down, and 01→10 and 10→01 give up. dbl_flip_o pulses together with that step when FLAG_EN=1.
- R7: Each pulse is registered. It is high for exactly the one cycle after the strobe edge, and step_up_o and step_dn_o are never high together.
- R8: phase_i passes through SYNC_STAGES (default 2) flip-flops before sampling. A change applied in the same cycle as a strobe is not seen by that strobe, but is seen by a strobe SYNC_STAGES or more cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample strobe, one cycle per sample period |
| phase_i | input | 2 | Encoder phases, asynchronous |
| step_up_o | output | 1 | One-cycle up step pulse |
| step_dn_o | output | 1 | One-cycle down step pulse |
| dbl_flip_o | output | 1 | Pulses with a step when both phases changed |

## Verification
A stored pair that is wrong does not show up at once. It only surfaces on the next strobe, as a missing pulse, an extra pulse, or a pulse in the wrong direction. For that reason each scenario strobes at a stable position before and after every change.

A wrong direction term shows up at the ports one cycle after the strobe. A synchroniser of the wrong depth appears as a pulse on a strobe that arrives too early.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;

  // 0 = up, 1 = down
  function automatic logic step_dir(phase_t chg, phase_t now);
    return chg[1] ^ now[0] ^ now[1];
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
  import qdec_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sample_en_i,
  input  phase_t now_i,
  output phase_t chg_o,
  output logic   dir_o
);
  phase_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prev_q <= '0;
    else if (sample_en_i) prev_q <= now_i;
  end

  assign chg_o = now_i ^ prev_q;
  assign dir_o = step_dir(chg_o, now_i);
endmodule

// File: rtl/quad_step_decoder.sv
module quad_step_decoder
  import qdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          FLAG_EN     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sample_en_i,
  input  logic [1:0] phase_i,
  output logic       step_up_o,
  output logic       step_dn_o,
  output logic       dbl_flip_o
);
  phase_t phase_sync;
  phase_t chg;
  logic   dir;
  logic   moved;
  logic   up_q, dn_q;

  qdec_sync #(.WIDTH(PHASE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (phase_i),
    .q_o   (phase_sync)
  );

  qdec_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_en_i(sample_en_i),
    .now_i      (phase_sync),
    .chg_o      (chg),
    .dir_o      (dir)
  );

  assign moved = sample_en_i && (chg != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= moved && !dir;
      dn_q <= moved &&  dir;
    end
  end

  if (FLAG_EN) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= moved && (&chg);
    end
    assign dbl_flip_o = flag_q;
  end else begin : g_noflag
    assign dbl_flip_o = 1'b0;
  end

  assign step_up_o = up_q;
  assign step_dn_o = dn_q;
endmodule

// File: rtl/qdec_chk.sv
module qdec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sample_en_i,
  input logic [1:0] phase_i,
  input logic       step_up_o,
  input logic       step_dn_o,
  input logic       dbl_flip_o
);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_up_o && step_dn_o));

  a_r2_up_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up_o |-> $past(sample_en_i));

  a_r2_dn_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dn_o |-> $past(sample_en_i));

  a_r6_flag_with_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_flip_o |-> (step_up_o || step_dn_o));

  a_r8_quiet_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> !(step_up_o || step_dn_o));

  logic unused_phase;
  assign unused_phase = ^phase_i;
endmodule

bind quad_step_decoder qdec_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_en_i(sample_en_i),
  .phase_i    (phase_i),
  .step_up_o  (step_up_o),
  .step_dn_o  (step_dn_o),
  .dbl_flip_o (dbl_flip_o)
);

// File: tb/quad_step_decoder_tb_top.sv
`timescale 1ns/100ps
module quad_step_decoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_en_i = 1'b0;
  logic [1:0] phase_i = 2'b00;
  logic       step_up_o, step_dn_o, dbl_flip_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  quad_step_decoder dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_en_i(sample_en_i),
    .phase_i    (phase_i),
    .step_up_o  (step_up_o),
    .step_dn_o  (step_dn_o),
    .dbl_flip_o (dbl_flip_o)
  );

  task automatic check(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {step_up_o, step_dn_o, dbl_flip_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {up,dn,flag} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_phase(logic [1:0] v);
    @(negedge clk_i) phase_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  // strobe one cycle, check the pulse cycle, then check it has gone
  task automatic strobe(string req, logic [2:0] exp);
    @(negedge clk_i) sample_en_i = 1'b1;
    @(negedge clk_i) sample_en_i = 1'b0;
    check(req, exp);
    @(negedge clk_i);
    check({req, " R7 width"}, 3'b000);
  endtask

  task automatic t_reset;
    check("R1 in reset", 3'b000);
    @(negedge clk_i) rst_ni = 1'b1;
    set_phase(2'b01);
    strobe("R1 first sample vs 00", 3'b010);
  endtask

  task automatic t_up;
    set_phase(2'b00); strobe("R4 01->00", 3'b100);
    set_phase(2'b10); strobe("R4 00->10", 3'b100);
    set_phase(2'b11); strobe("R4 10->11", 3'b100);
    set_phase(2'b01); strobe("R4 11->01", 3'b100);
    set_phase(2'b00); strobe("R4 01->00 wrap", 3'b100);
  endtask

  task automatic t_down;
    set_phase(2'b01); strobe("R5 00->01", 3'b010);
    set_phase(2'b11); strobe("R5 01->11", 3'b010);
    set_phase(2'b10); strobe("R5 11->10", 3'b010);
    set_phase(2'b00); strobe("R5 10->00", 3'b010);
  endtask

  task automatic t_idle;
    strobe("R3 no change", 3'b000);
    @(negedge clk_i) phase_i = 2'b01;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      check("R2 no strobe", 3'b000);
    end
    set_phase(2'b00);
    strobe("R2 state kept at 00", 3'b000);
  endtask

  task automatic t_double;
    set_phase(2'b11); strobe("R6 00->11", 3'b011);
    set_phase(2'b00); strobe("R6 11->00", 3'b011);
    set_phase(2'b01); strobe("R6 single 00->01", 3'b010);
    set_phase(2'b10); strobe("R6 01->10", 3'b101);
    set_phase(2'b01); strobe("R6 10->01", 3'b101);
  endtask

  task automatic t_sync;
    set_phase(2'b11); strobe("R8 setup 01->11", 3'b010);
    set_phase(2'b10); strobe("R8 setup 11->10", 3'b010);
    @(negedge clk_i) begin phase_i = 2'b00; sample_en_i = 1'b1; end
    @(negedge clk_i) sample_en_i = 1'b0;
    check("R8 same-cycle change unseen", 3'b000);
    repeat (2) @(negedge clk_i);
    strobe("R8 seen later 10->00", 3'b010);
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    t_up;
    t_down;
    t_idle;
    t_double;
    t_sync;
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule